// File: doc/BRIEF.md
# Prioritized Interrupt Front End

This block sits between the external interrupt request pins and the control sequencer of a small 8-bit processor. It watches five request lines with three kinds of sensitivity: a non-maskable line that must rise and then stay high, an edge-latched maskable line, two level-sensitive maskable lines, and one general request. It holds the global interrupt enable, the three per-line mask bits and the edge request latch. It also filters the non-maskable line, so that a held-high level cannot re-trigger it.

At every instruction boundary the core raises `instr_done`. If a serviceable request exists at that point, the unit picks the winner by fixed priority and clears the global enable. For the four fixed lines it hands the core a 16-bit restart address one cycle later. For the general request it first runs a one-cycle acknowledge, during which external logic drives a restart opcode of the form 11NNN111 onto `vec_in`, and it then hands over the address 8*N. The stack pushes and the program counter load stay with the core. The core can also write the mask register, enable or disable interrupts, and read a status byte.

Top module: `irq_front`

## Requirements
- R1: After reset `mask_status` reads 0x07 (all three masks set, enable clear, nothing pending), and `svc_valid`, `gen_ack` and `irq_pend` are low.
- R2: The fixed priority from highest to lowest is non-maskable, edge line, high level line, low level line, general request; `svc_src` reports the winner as 1, 2, 3, 4 or 5 respectively (0 = none).
- R3: The non-maskable line is serviced whatever the enable and masks hold. It becomes pending only after a low-to-high transition that is followed by the line staying high, and once taken it is not taken again until the line has gone low and then high again.
- R4: The edge, high level and low level lines are serviced only when the global enable is set and their own mask bit is clear. `setmask_stb` with `setmask_data[3]`=1 loads the masks from `setmask_data[2:0]`: bit 0 masks the low level line, bit 1 the high level line, bit 2 the edge line.
- R5: The general request ignores the mask bits and depends only on the global enable. When it is taken, `gen_ack` is high for exactly the next cycle, `vec_in` is sampled in that cycle, and in the cycle after that `svc_valid` is high with `svc_src`=5 and `svc_addr` = 8 * `vec_in[5:3]`.
- R6: A rising edge on the edge line sets an internal request latch. The latch holds until that request is taken, until `setmask_stb` arrives with `setmask_data[4]`=1 (a clear that wins over a simultaneous edge), or until reset. The level lines have no latch.
- R7: An `en_stb` arms the enable. The enable turns on at the first `instr_done` after the strobe, and requests at that same boundary still see the old, cleared enable. `dis_stb` clears both the enable and the armed state at once.
- R8: Taking any request clears the global enable and any armed enable.
- R9: A request is taken only in a cycle with `instr_done` high and `gen_ack` low, and `irq_pend` shows exactly that such a request exists. For fixed lines `svc_valid` rises in the next cycle, with the address 0x0024 (non-maskable), 0x003C (edge), 0x0034 (high level) or 0x002C (low level).
- R10: `mask_status` bits: [2:0] masks, [3] global enable, [4] low level line, [5] high level line, [6] edge latch, [7] zero.
- R11: Every request pin passes through a SYNC_STAGES-flop synchronizer before any logic sees it. With the default of 2, a pin change shows up in `mask_status` two clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trap_pin | input | 1 | Non-maskable request pin |
| edge_pin | input | 1 | Rising-edge maskable request pin |
| lvl_hi_pin | input | 1 | Higher-priority level request pin |
| lvl_lo_pin | input | 1 | Lower-priority level request pin |
| gen_pin | input | 1 | General request pin needing an acknowledge |
| instr_done | input | 1 | Instruction boundary strobe from the core |
| en_stb | input | 1 | Enable-interrupts strobe |
| dis_stb | input | 1 | Disable-interrupts strobe |
| setmask_stb | input | 1 | Mask write / edge clear strobe |
| setmask_data | input | 5 | [2:0] masks, [3] mask write enable, [4] edge latch clear |
| mask_status | output | 8 | Read-mask status byte |
| irq_pend | output | 1 | A serviceable request exists |
| vec_in | input | 8 | Restart opcode driven during the acknowledge |
| gen_ack | output | 1 | Acknowledge cycle for the general request |
| svc_valid | output | 1 | One-cycle strobe: restart address is valid |
| svc_addr | output | 16 | Restart address |
| svc_src | output | 3 | Winning source code |

## Verification
The assertions assume the core never raises `en_stb` and `dis_stb` in the same cycle. They also assume that the general request's opcode is on `vec_in` during the cycle in which `gen_ack` is high. The stimulus drives each strobe alone for a single cycle and sets `vec_in` before the acknowledge starts. Pins are changed at most once per cycle, away from the clock edge, and held long enough to cross the synchronizer before the boundary that is meant to see them.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W     = 16;
  localparam int N_SRC      = 5;
  localparam int SM_W       = 5;
  localparam int SM_WR_BIT  = 3;
  localparam int SM_CLR_BIT = 4;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_EDGE = 3'd2,
    SRC_HI   = 3'd3,
    SRC_LO   = 3'd4,
    SRC_GEN  = 3'd5
  } src_e;

  function automatic logic [ADDR_W-1:0] fixed_vec(src_e s);
    case (s)
      SRC_TRAP: fixed_vec = ADDR_W'(16'h0024);
      SRC_EDGE: fixed_vec = ADDR_W'(16'h003C);
      SRC_HI:   fixed_vec = ADDR_W'(16'h0034);
      SRC_LO:   fixed_vec = ADDR_W'(16'h002C);
      default:  fixed_vec = '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain[STAGES-1];
endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_qual.sv
module irq_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_s,
  input  logic edge_s,
  input  logic clr_trap,
  input  logic clr_edge,
  output logic trap_req,
  output logic edge_req
);
  logic trap_prev, trap_arm, edge_prev, edge_lat;
  logic trap_arm_n, edge_lat_n;

  always_comb begin
    if (!trap_s)                trap_arm_n = 1'b0;
    else if (clr_trap)          trap_arm_n = 1'b0;
    else if (!trap_prev)        trap_arm_n = 1'b1;
    else                        trap_arm_n = trap_arm;

    if (clr_edge)               edge_lat_n = 1'b0;
    else if (edge_s && !edge_prev) edge_lat_n = 1'b1;
    else                        edge_lat_n = edge_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_prev <= 1'b0;
      trap_arm  <= 1'b0;
      edge_prev <= 1'b0;
      edge_lat  <= 1'b0;
    end else begin
      trap_prev <= trap_s;
      trap_arm  <= trap_arm_n;
      edge_prev <= edge_s;
      edge_lat  <= edge_lat_n;
    end
  end

  assign trap_req = trap_arm & trap_s;
  assign edge_req = edge_lat;
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_pkg::*;
(
  input  logic       trap_req,
  input  logic       edge_req,
  input  logic       hi_req,
  input  logic       lo_req,
  input  logic       gen_req,
  input  logic       ie,
  input  logic [2:0] mask,
  output src_e       win,
  output logic       any
);
  logic [N_SRC-1:0] qual;

  always_comb begin
    qual[0] = trap_req;
    qual[1] = edge_req & ie & ~mask[2];
    qual[2] = hi_req   & ie & ~mask[1];
    qual[3] = lo_req   & ie & ~mask[0];
    qual[4] = gen_req  & ie;
    win = SRC_NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (qual[i]) win = src_e'(3'(i + 1));
    end
    any = |qual;
  end
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_pin,
  input  logic              edge_pin,
  input  logic              lvl_hi_pin,
  input  logic              lvl_lo_pin,
  input  logic              gen_pin,
  input  logic              instr_done,
  input  logic              en_stb,
  input  logic              dis_stb,
  input  logic              setmask_stb,
  input  logic [SM_W-1:0]   setmask_data,
  output logic [7:0]        mask_status,
  output logic              irq_pend,
  input  logic [7:0]        vec_in,
  output logic              gen_ack,
  output logic              svc_valid,
  output logic [ADDR_W-1:0] svc_addr,
  output logic [2:0]        svc_src
);
  logic       rst_i;
  logic [4:0] pins_s;
  logic       trap_req, edge_req, any;
  src_e       win;

  logic       ie, ie_n, arm, arm_n, busy, busy_n;
  logic [2:0] mask, mask_n;
  logic       valid_q, valid_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  src_e       src_q, src_n;
  logic       take, clr_edge, clr_trap;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_i)
  );

  irq_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i),
    .d({gen_pin, lvl_lo_pin, lvl_hi_pin, edge_pin, trap_pin}),
    .q(pins_s)
  );

  irq_qual u_qual (
    .clk(clk), .rst_n(rst_i),
    .trap_s(pins_s[0]), .edge_s(pins_s[1]),
    .clr_trap(clr_trap), .clr_edge(clr_edge),
    .trap_req(trap_req), .edge_req(edge_req)
  );

  irq_prio u_prio (
    .trap_req(trap_req), .edge_req(edge_req),
    .hi_req(pins_s[2]), .lo_req(pins_s[3]), .gen_req(pins_s[4]),
    .ie(ie), .mask(mask), .win(win), .any(any)
  );

  always_comb begin
    take     = instr_done & any & ~busy;
    clr_trap = take && (win == SRC_TRAP);
    clr_edge = (setmask_stb && setmask_data[SM_CLR_BIT]) ||
               (take && (win == SRC_EDGE));

    ie_n  = ie;
    arm_n = arm;
    if (instr_done && arm) begin
      ie_n  = 1'b1;
      arm_n = 1'b0;
    end
    if (en_stb) arm_n = 1'b1;
    if (dis_stb || take) begin
      ie_n  = 1'b0;
      arm_n = 1'b0;
    end

    mask_n = mask;
    if (setmask_stb && setmask_data[SM_WR_BIT]) mask_n = setmask_data[2:0];

    valid_n = 1'b0;
    busy_n  = 1'b0;
    addr_n  = addr_q;
    src_n   = src_q;
    if (busy) begin
      valid_n = 1'b1;
      addr_n  = {{(ADDR_W-8){1'b0}}, vec_in & 8'h38};
      src_n   = SRC_GEN;
    end else if (take) begin
      if (win == SRC_GEN) begin
        busy_n = 1'b1;
      end else begin
        valid_n = 1'b1;
        addr_n  = fixed_vec(win);
        src_n   = win;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ie      <= 1'b0;
      arm     <= 1'b0;
      mask    <= 3'b111;
      busy    <= 1'b0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      src_q   <= SRC_NONE;
    end else begin
      ie      <= ie_n;
      arm     <= arm_n;
      mask    <= mask_n;
      busy    <= busy_n;
      valid_q <= valid_n;
      if (valid_n) begin
        addr_q <= addr_n;
        src_q  <= src_n;
      end
    end
  end

  assign mask_status = {1'b0, edge_req, pins_s[2], pins_s[3], ie, mask};
  assign irq_pend    = any & ~busy;
  assign gen_ack     = busy;
  assign svc_valid   = valid_q;
  assign svc_addr    = addr_q;
  assign svc_src     = src_q;
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_done,
  input logic [7:0]  mask_status,
  input logic        irq_pend,
  input logic        gen_ack,
  input logic        svc_valid,
  input logic [15:0] svc_addr,
  input logic [2:0]  svc_src
);
  AST_SRC_NAMED: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (svc_src != 3'd0)); // R2
  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_src == 3'd1) |-> (svc_addr == 16'h0024)); // R9
  AST_TAKE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> !mask_status[3]); // R8
  AST_ACK_THEN_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ack |=> (svc_valid && svc_src == 3'd5)); // R5
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ack |=> !gen_ack); // R5
  AST_GEN_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_src == 3'd5) |-> (svc_addr[2:0] == 3'd0 && svc_addr[15:6] == 10'd0)); // R5
  AST_NO_PEND_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    gen_ack |-> !irq_pend); // R9
  AST_BOUNDARY_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && irq_pend) |=> (svc_valid || gen_ack)); // R9
  AST_IE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_status[3]) |-> $past(instr_done)); // R7
endmodule

bind irq_front irq_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
  .mask_status(mask_status), .irq_pend(irq_pend), .gen_ack(gen_ack),
  .svc_valid(svc_valid), .svc_addr(svc_addr), .svc_src(svc_src)
);

// File: tb/irq_front_test.sv
module irq_front_test;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic trap_pin, edge_pin, lvl_hi_pin, lvl_lo_pin, gen_pin;
  logic instr_done, en_stb, dis_stb, setmask_stb;
  logic [4:0]  setmask_data;
  logic [7:0]  vec_in;
  logic [7:0]  mask_status;
  logic        irq_pend, gen_ack, svc_valid;
  logic [15:0] svc_addr;
  logic [2:0]  svc_src;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit active = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  irq_front #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n),
    .trap_pin(trap_pin), .edge_pin(edge_pin), .lvl_hi_pin(lvl_hi_pin),
    .lvl_lo_pin(lvl_lo_pin), .gen_pin(gen_pin),
    .instr_done(instr_done), .en_stb(en_stb), .dis_stb(dis_stb),
    .setmask_stb(setmask_stb), .setmask_data(setmask_data),
    .mask_status(mask_status), .irq_pend(irq_pend), .vec_in(vec_in),
    .gen_ack(gen_ack), .svc_valid(svc_valid), .svc_addr(svc_addr),
    .svc_src(svc_src)
  );

  // behavioural reference model
  bit [4:0] m_pipe [SYNC];
  bit m_ie, m_arm, m_tprev, m_tarm, m_eprev, m_elat, m_busy, m_valid;
  bit [2:0] m_mask;
  int m_addr, m_src;

  function automatic int m_winner();
    bit [4:0] c = m_pipe[SYNC-1];
    if (m_tarm && c[0]) return 1;
    if (m_ie) begin
      if (m_elat && !m_mask[2]) return 2;
      if (c[2] && !m_mask[1]) return 3;
      if (c[3] && !m_mask[0]) return 4;
      if (c[4]) return 5;
    end
    return 0;
  endfunction

  function automatic int m_vec(int w);
    case (w)
      1: return 'h24;
      2: return 'h3C;
      3: return 'h34;
      4: return 'h2C;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < SYNC; i++) m_pipe[i] = '0;
    m_ie = 0; m_arm = 0; m_tprev = 0; m_tarm = 0; m_eprev = 0; m_elat = 0;
    m_busy = 0; m_valid = 0; m_mask = 3'b111; m_addr = 0; m_src = 0;
  endtask

  always @(posedge clk) begin
    if (active) begin
      bit [4:0] c;
      int w;
      bit take, n_ie, n_arm, n_tarm, n_elat, n_busy, n_valid;
      int n_addr, n_src;
      c = m_pipe[SYNC-1];
      w = m_winner();
      take = instr_done && (w != 0) && !m_busy;
      n_ie = m_ie; n_arm = m_arm;
      if (instr_done && m_arm) begin n_ie = 1; n_arm = 0; end
      if (en_stb) n_arm = 1;
      if (dis_stb || take) begin n_ie = 0; n_arm = 0; end
      if (!c[0] || (take && w == 1)) n_tarm = 0;
      else if (!m_tprev) n_tarm = 1;
      else n_tarm = m_tarm;
      if ((setmask_stb && setmask_data[4]) || (take && w == 2)) n_elat = 0;
      else if (c[1] && !m_eprev) n_elat = 1;
      else n_elat = m_elat;
      n_busy = 0; n_valid = 0; n_addr = m_addr; n_src = m_src;
      if (m_busy) begin
        n_valid = 1; n_src = 5; n_addr = int'(vec_in[5:3]) * 8;
      end else if (take) begin
        if (w == 5) n_busy = 1;
        else begin n_valid = 1; n_src = w; n_addr = m_vec(w); end
      end
      if (setmask_stb && setmask_data[3]) m_mask = setmask_data[2:0];
      m_tprev = c[0]; m_eprev = c[1];
      m_ie = n_ie; m_arm = n_arm; m_tarm = n_tarm; m_elat = n_elat;
      m_busy = n_busy; m_valid = n_valid; m_addr = n_addr; m_src = n_src;
      for (int i = SYNC - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = {gen_pin, lvl_lo_pin, lvl_hi_pin, edge_pin, trap_pin};
    end
  end

  task automatic fail(string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s actual=0x%0h expected=0x%0h", cur_req, what, act, exp);
  endtask

  task automatic cmp();
    bit [4:0] c = m_pipe[SYNC-1];
    int st = {1'b0, m_elat, c[2], c[3], m_ie, m_mask};
    int pd = (m_winner() != 0 && !m_busy) ? 1 : 0;
    vectors++;
    if (mask_status !== 8'(st))   fail("mask_status", mask_status, st);
    if (irq_pend !== pd[0])       fail("irq_pend", irq_pend, pd);
    if (gen_ack !== m_busy)       fail("gen_ack", gen_ack, m_busy);
    if (svc_valid !== m_valid)    fail("svc_valid", svc_valid, m_valid);
    if (svc_addr !== 16'(m_addr)) fail("svc_addr", svc_addr, m_addr);
    if (svc_src !== 3'(m_src))    fail("svc_src", svc_src, m_src);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (active) cmp();
  endtask

  task automatic step(int n);
    repeat (n) tick();
  endtask

  task automatic boundary();
    instr_done = 1; tick(); instr_done = 0;
  endtask

  task automatic enable();
    en_stb = 1; tick(); en_stb = 0; boundary();
  endtask

  task automatic setmask(logic [4:0] d);
    setmask_stb = 1; setmask_data = d; tick(); setmask_stb = 0; setmask_data = '0;
  endtask

  task automatic pulse_edge();
    edge_pin = 1; tick(); edge_pin = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    {trap_pin, edge_pin, lvl_hi_pin, lvl_lo_pin, gen_pin} = '0;
    {instr_done, en_stb, dis_stb, setmask_stb} = '0;
    setmask_data = '0; vec_in = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    active = 1;

    // R1 reset state
    cur_req = "R1";
    chk("R1", "mask_status", mask_status, 8'h07);
    chk("R1", "svc_valid", svc_valid, 0);
    chk("R1", "gen_ack", gen_ack, 0);
    chk("R1", "irq_pend", irq_pend, 0);

    // R3 non-maskable: accepted with enable clear, no re-take while held
    cur_req = "R3";
    trap_pin = 1; step(4);
    chk("R3", "irq_pend", irq_pend, 1);
    boundary();
    chk("R9", "svc_src", svc_src, 1);
    chk("R9", "svc_addr", svc_addr, 16'h0024);
    step(1); boundary();
    chk("R3", "svc_valid held high", svc_valid, 0);
    trap_pin = 0; step(4); trap_pin = 1; step(4); boundary();
    chk("R3", "svc_valid re-armed", svc_valid, 1);
    trap_pin = 0; step(4);
    trap_pin = 1; tick(); trap_pin = 0; step(4);
    chk("R3", "irq_pend glitch", irq_pend, 0);

    // R4 maskables blocked while enable clear; R10 pending bits
    cur_req = "R4";
    lvl_hi_pin = 1; step(4);
    chk("R10", "hi pending bit", mask_status[5], 1);
    chk("R4", "irq_pend masked", irq_pend, 0);
    boundary();
    chk("R4", "svc_valid masked", svc_valid, 0);

    // R7 enable takes effect one boundary late
    cur_req = "R7";
    setmask(5'h08);
    chk("R4", "mask bits cleared", mask_status[2:0], 0);
    chk("R4", "irq_pend ie off", irq_pend, 0);
    en_stb = 1; tick(); en_stb = 0;
    boundary();
    chk("R7", "svc_valid first boundary", svc_valid, 0);
    chk("R7", "ie set", mask_status[3], 1);
    boundary();
    chk("R9", "hi src", svc_src, 3);
    chk("R9", "hi addr", svc_addr, 16'h0034);
    chk("R8", "ie cleared", mask_status[3], 0);
    lvl_hi_pin = 0; step(3);

    // R2 priority ordering, R6 latch
    cur_req = "R2";
    pulse_edge(); lvl_lo_pin = 1; gen_pin = 1; lvl_hi_pin = 1; step(4);
    chk("R10", "pending bits", mask_status[6:4], 3'b111);
    enable(); boundary();
    chk("R2", "edge first", svc_src, 2);
    chk("R9", "edge addr", svc_addr, 16'h003C);
    chk("R6", "latch cleared by take", mask_status[6], 0);
    chk("R8", "ie cleared", mask_status[3], 0);
    boundary();
    chk("R8", "no nested take", svc_valid, 0);
    enable(); boundary();
    chk("R2", "hi second", svc_src, 3);
    lvl_hi_pin = 0; step(3);
    enable(); boundary();
    chk("R2", "lo third", svc_src, 4);
    chk("R9", "lo addr", svc_addr, 16'h002C);
    lvl_lo_pin = 0; step(3);
    cur_req = "R5";
    vec_in = 8'hEF;
    enable(); boundary();
    chk("R5", "gen_ack", gen_ack, 1);
    chk("R5", "svc_valid during ack", svc_valid, 0);
    tick();
    chk("R5", "gen src", svc_src, 5);
    chk("R5", "gen addr", svc_addr, 16'h0028);
    gen_pin = 0; step(3);

    // R6 clear by set-mask
    cur_req = "R6";
    pulse_edge(); step(4);
    chk("R6", "latched", mask_status[6], 1);
    setmask(5'h10);
    chk("R6", "cleared", mask_status[6], 0);
    chk("R6", "masks untouched", mask_status[2:0], 0);
    setmask(5'h0C);
    pulse_edge(); step(4);
    enable(); boundary();
    chk("R4", "edge masked", svc_valid, 0);
    chk("R6", "latch held while masked", mask_status[6], 1);
    setmask(5'h08); boundary();
    chk("R4", "edge unmasked", svc_src, 2);

    // R5 general request ignores masks
    cur_req = "R5";
    setmask(5'h0F);
    gen_pin = 1; vec_in = 8'hFF; step(4);
    enable();
    chk("R5", "irq_pend all masked", irq_pend, 1);
    boundary();
    chk("R5", "gen_ack", gen_ack, 1);
    tick();
    chk("R5", "gen addr N=7", svc_addr, 16'h0038);
    gen_pin = 0; step(3);

    // R11 synchronizer latency, R7 disable
    cur_req = "R11";
    setmask(5'h08);
    lvl_lo_pin = 1; tick();
    chk("R11", "one edge", mask_status[4], 0);
    tick();
    chk("R11", "two edges", mask_status[4], 1);
    step(2);
    cur_req = "R7";
    enable();
    dis_stb = 1; tick(); dis_stb = 0;
    chk("R7", "ie after disable", mask_status[3], 0);
    boundary();
    chk("R7", "no take after disable", svc_valid, 0);
    lvl_lo_pin = 0; step(4);

    finished = 1;
    summary();
    $finish;
  end
endmodule